// File: doc/BRIEF.md
# Edge-Cleared Watchdog Monitor

This block watches a single activity line driven by a processor and raises a fault when that line holds still for longer than a programmed number of clock cycles. Every change on the line counts as proof of life, whether it goes up or down. Each change restarts the count. The line is asynchronous to the block's clock, so it passes through a synchronizer first. Changes are found by comparing the synchronized level with its value one clock earlier.

The fault output is active-low. After a timeout it stays low until the processor toggles the line again. It is also pulled low, with no clock delay, whenever the supply-good flag from the reset logic is low, and it returns high as soon as that flag comes back. While the system reset from the reset logic is active, the counter is held at zero and any latched fault is cleared. Counting starts on the first cycle after that reset releases. Because of this, when the fault output is looped back into the reset logic as a manual reset and the line never toggles, a reset is produced once per timeout plus the reset hold time. An enable input turns the whole function off.

Top module: `wdog_edge_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, the internal counter and fault flag clear; after reset, `wd_fault_n` equals `supply_ok`.
- R2: Once counting starts (after release of `rst_n`, `sys_rst_act` or a disable, or after a transition clears the counter), `wd_fault_n` stays high through `TIMEOUT_CYC` rising clock edges and goes low after edge `TIMEOUT_CYC`+1, provided no transition arrives.
- R3: A rising transition on `wd_in` clears the counter `SYNC_STAGES`+1 clock edges after it is applied, and the full timeout restarts from there.
- R4: A falling transition on `wd_in` clears the counter in the same way as a rising one.
- R5: A timeout fault stays latched, with `wd_fault_n` low, until a transition on `wd_in`. The output returns high after `SYNC_STAGES`+1 clock edges.
- R6: While `sys_rst_act` is 1, the counter is held at zero and a latched fault is cleared one edge later. Counting begins at the first edge after release.
- R7: `supply_ok` = 0 drives `wd_fault_n` low at once, with no clock edge needed, even when no timeout has occurred.
- R8: When `supply_ok` returns to 1 and no fault is latched, `wd_fault_n` goes high at once.
- R9: With `wd_en` = 0, the counter and fault are held clear and `wd_fault_n` follows `supply_ok` for any length of time. A latched fault clears one edge after `wd_en` falls.
- R10: A pulse on `wd_in` that spans a single rising clock edge is seen as two transitions.
- R11: If `wd_fault_n` is looped into reset logic that holds `sys_rst_act` for H edges per fault, and `wd_in` never toggles, faults recur every `TIMEOUT_CYC`+H+1 clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset of the block's registers |
| wd_in | input | 1 | Asynchronous activity line from the processor |
| sys_rst_act | input | 1 | System reset currently asserted (from reset logic) |
| supply_ok | input | 1 | Supply above threshold (from reset logic) |
| wd_en | input | 1 | 1 enables the watchdog; 0 disables it |
| wd_fault_n | output | 1 | Active-low watchdog fault |

## Verification
The hardest case to reach from the ports is the recurring reset of R11. That loop needs an outside party that reacts to the block's own fault by asserting system reset, holds it, and then lets the count run out again with the line kept still. The bench plays that reset logic inside a task. It watches `wd_fault_n` on falling clock edges, drives `sys_rst_act` for a fixed hold, and counts clock edges between two successive faults. It then compares that count with the expected period. Transitions placed just before a deadline (R3, R4, R10) are timed to the edge, so that a late clear would show up as a fault.

// File: rtl/wdog_pkg.sv
// Package: shared defaults for the edge-cleared watchdog.
// Assumes a 125 MHz clock for the default timeout value.
package wdog_pkg;
    // 1.6 s expressed in cycles of a 125 MHz clock
    localparam int unsigned DEF_TIMEOUT_CYC = 200_000_000;
    // flops in the input synchronizer
    localparam int unsigned DEF_SYNC_STAGES = 2;
endpackage

// File: rtl/wdog_edge_det.sv
// Module: wdog_edge_det
// Brings an asynchronous line into the clock domain with a flop chain.
// Flags a one-cycle pulse whenever the synchronized level changes,
// in either direction.
// Assumes SYNC_STAGES >= 2 and a synchronous active-low reset.
module wdog_edge_det #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic edge_seen
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    // synchronizer chain: stage 0 samples the raw line
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], din};
    end

    // previous synchronized level, used for change detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    // any difference between current and previous level is a transition
    always_comb edge_seen = sync_q[SYNC_STAGES-1] ^ prev_q;
endmodule

// File: rtl/wdog_timer.sv
// Module: wdog_timer
// Counts clock cycles up to a limit and then saturates there.
// A clear request wins over counting.
// Assumes TIMEOUT_CYC >= 1.
module wdog_timer #(
    parameter int unsigned TIMEOUT_CYC = 16,
    parameter int unsigned CNT_W       = $clog2(TIMEOUT_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt_q,
    output logic             expired
);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);

    // saturating up-counter, cleared by reset or clear
    always_ff @(posedge clk) begin
        if (!rst_n || clear)     cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    // limit reached
    always_comb expired = (cnt_q == LIMIT);
endmodule

// File: rtl/wdog_edge_monitor.sv
// Module: wdog_edge_monitor (top)
// Watchdog whose timer is cleared by any change on wd_in.
// A timeout latches an active-low fault that holds until the next change.
// Low supply forces the fault output low with no clock delay.
// System reset or a disable holds the timer cleared and drops the latch.
// Assumes sys_rst_act and supply_ok are already synchronous to clk.
module wdog_edge_monitor #(
    parameter int unsigned TIMEOUT_CYC = wdog_pkg::DEF_TIMEOUT_CYC,
    parameter int unsigned SYNC_STAGES = wdog_pkg::DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_in,
    input  logic sys_rst_act,
    input  logic supply_ok,
    input  logic wd_en,
    output logic wd_fault_n
);
    localparam int unsigned CNT_W = $clog2(TIMEOUT_CYC + 1);

    logic             edge_seen;
    logic             tmr_clear;
    logic [CNT_W-1:0] cnt_q;
    logic             expired;
    logic             fault_q;

    wdog_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (wd_in),
        .edge_seen (edge_seen)
    );

    // anything that restarts the timeout window
    always_comb tmr_clear = edge_seen | sys_rst_act | ~wd_en;

    wdog_timer #(.TIMEOUT_CYC(TIMEOUT_CYC), .CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (tmr_clear),
        .cnt_q   (cnt_q),
        .expired (expired)
    );

    // fault latch: set on expiry, cleared by any restart condition
    always_ff @(posedge clk) begin
        if (!rst_n || tmr_clear) fault_q <= 1'b0;
        else if (expired)        fault_q <= 1'b1;
    end

    // output: low on latched fault or on low supply, with no delay
    always_comb wd_fault_n = supply_ok & ~fault_q;
endmodule

// File: rtl/wdog_edge_monitor_chk.sv
// Module: wdog_edge_monitor_chk
// Property checker attached to the top module through bind.
// Observes ports and internal stage outputs only.
module wdog_edge_monitor_chk #(
    parameter int unsigned TIMEOUT_CYC = 16,
    parameter int unsigned CNT_W       = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sys_rst_act,
    input logic             supply_ok,
    input logic             wd_en,
    input logic             wd_fault_n,
    input logic             edge_seen,
    input logic [CNT_W-1:0] cnt_q,
    input logic             fault_q
);
    p_hold_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_act |=> (cnt_q == '0));

    p_edge_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        edge_seen |=> (cnt_q == '0));

    p_supply_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |-> !wd_fault_n);

    p_disabled_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!wd_en) && supply_ok) |-> wd_fault_n);

    p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (supply_ok && $past(supply_ok) && !$past(wd_fault_n) && !$past(edge_seen)
         && !$past(sys_rst_act) && $past(wd_en)) |-> !wd_fault_n);

    p_set_at_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_q) |-> ($past(cnt_q) == CNT_W'(TIMEOUT_CYC)));

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(TIMEOUT_CYC));
endmodule

bind wdog_edge_monitor wdog_edge_monitor_chk #(
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .CNT_W       (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_rst_act (sys_rst_act),
    .supply_ok   (supply_ok),
    .wd_en       (wd_en),
    .wd_fault_n  (wd_fault_n),
    .edge_seen   (edge_seen),
    .cnt_q       (cnt_q),
    .fault_q     (fault_q)
);

// File: tb/sim_wdog_edge_monitor.sv
// Directed bench: one task per scenario, each checking its own results.
// Inputs are driven and outputs are sampled on falling clock edges.
module sim_wdog_edge_monitor;
    localparam int T = 16;
    localparam int S = 2;
    localparam int H = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wd_in = 1'b0;
    logic sys_rst_act = 1'b0;
    logic supply_ok = 1'b1;
    logic wd_en = 1'b1;
    logic wd_fault_n;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    wdog_edge_monitor #(.TIMEOUT_CYC(T), .SYNC_STAGES(S)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .wd_in       (wd_in),
        .sys_rst_act (sys_rst_act),
        .supply_ok   (supply_ok),
        .wd_en       (wd_en),
        .wd_fault_n  (wd_fault_n)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: wd_fault_n=%b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // toggle the line and wait until the counter is cleared
    task automatic restart();
        wd_in = ~wd_in;
        step(S + 1);
    endtask

    task automatic t_reset_r1();
        step(3);
        chk(wd_fault_n, 1'b1, "R1 reset state");
        rst_n = 1'b1;
        step(T);
        chk(wd_fault_n, 1'b1, "R2 high through limit after reset");
        step(1);
        chk(wd_fault_n, 1'b0, "R2 fault after limit+1");
    endtask

    task automatic t_latch_r5();
        step(7);
        chk(wd_fault_n, 1'b0, "R5 fault stays latched");
        wd_in = ~wd_in;
        step(S);
        chk(wd_fault_n, 1'b0, "R5 still low before clear edge");
        step(1);
        chk(wd_fault_n, 1'b1, "R5 released by transition");
    endtask

    task automatic t_edge_dir(input logic want_rise, input string tag);
        restart();
        if (wd_in == want_rise) restart();
        step(T - 3);
        wd_in = want_rise;
        step(S + 1);
        step(T);
        chk(wd_fault_n, 1'b1, tag);
        step(1);
        chk(wd_fault_n, 1'b0, tag);
    endtask

    task automatic t_pulse_r10();
        restart();
        step(T - 3);
        wd_in = ~wd_in;
        step(1);
        wd_in = ~wd_in;
        step(S + 1);
        step(T);
        chk(wd_fault_n, 1'b1, "R10 pulse counted, no early fault");
        step(1);
        chk(wd_fault_n, 1'b0, "R10 timeout from second transition");
    endtask

    task automatic t_supply_r7_r8();
        restart();
        supply_ok = 1'b0;
        #1;
        chk(wd_fault_n, 1'b0, "R7 low supply forces fault at once");
        step(1);
        supply_ok = 1'b1;
        #1;
        chk(wd_fault_n, 1'b1, "R8 supply return releases at once");
    endtask

    task automatic t_sysrst_r6();
        restart();
        step(T + 2);
        chk(wd_fault_n, 1'b0, "R6 precondition fault latched");
        sys_rst_act = 1'b1;
        step(1);
        chk(wd_fault_n, 1'b1, "R6 system reset clears latch");
        step(3 * T);
        chk(wd_fault_n, 1'b1, "R6 no count during system reset");
        sys_rst_act = 1'b0;
        step(T);
        chk(wd_fault_n, 1'b1, "R6 counting restarts on release");
        step(1);
        chk(wd_fault_n, 1'b0, "R6 fault after limit+1 from release");
    endtask

    task automatic t_disable_r9();
        wd_en = 1'b0;
        step(1);
        chk(wd_fault_n, 1'b1, "R9 disable clears latched fault");
        step(3 * T);
        chk(wd_fault_n, 1'b1, "R9 no timeout while disabled");
        wd_en = 1'b1;
        step(T);
        chk(wd_fault_n, 1'b1, "R9 counting from enable");
        step(1);
        chk(wd_fault_n, 1'b0, "R9 fault after re-enable");
    endtask

    task automatic t_loop_r11();
        int gap;
        restart();
        while (wd_fault_n) step(1);
        for (int k = 0; k < 2; k++) begin
            sys_rst_act = 1'b1;
            step(H);
            sys_rst_act = 1'b0;
            gap = H;
            while (wd_fault_n && gap < 4 * T) begin
                step(1);
                gap++;
            end
            n_checks++;
            if (gap != T + H + 1) begin
                n_errors++;
                $display("FAIL R11 loop period: got %0d expected %0d", gap, T + H + 1);
            end
        end
    endtask

    initial begin
        step(1);
        t_reset_r1();
        t_latch_r5();
        t_edge_dir(1'b1, "R3 rising clears timer");
        t_edge_dir(1'b0, "R4 falling clears timer");
        t_pulse_r10();
        t_supply_r7_r8();
        t_sysrst_r6();
        t_disable_r9();
        t_loop_r11();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule